// File: doc/BRIEF.md
# System-Management Base Relocation Unit

This block belongs to one processor core. It holds that core's private base register for system-management memory. From the base it derives the addresses the core needs when it enters management mode: the handler entry point, the upper and lower bounds of the state-save area, and the fixed slot that stores the base itself. Every core gets its own copy of the unit, with its own reset base if needed, so the cores' regions can sit at different addresses, for example 1000h apart.

On an entry request the unit first writes its current base into the save slot through a simple request/acknowledge memory port. Only after that write is acknowledged does it flag the entry address as valid. On a resume request it reads the save slot back and adopts the value it finds there. A handler therefore moves the region by editing that saved word, and the move takes effect at the next entry.

Top module: `sysmgmt_base_unit`

## Requirements
- R1: After reset the base output reads 0003_0000h, and inSmm, entryValid, saveDone and memReq are all 0.
- R2: While entryValid is high, entryAddr equals base + 8000h, so the first entry after reset presents 0003_8000h.
- R3: An smiReq seen while inSmm is 0 starts one write with memWe=1, memAddr = base + FEF8h and memWdata = base. memReq, memWe, memAddr and memWdata hold steady until a cycle in which memAck is high.
- R4: entryValid and saveDone both rise in the cycle after the save write is acknowledged. saveDone is high for exactly one cycle. inSmm is high from the cycle after smiReq is accepted until the resume read completes.
- R5: saveHi equals base + FFFFh. saveLo equals base + FE00h when wideMode was 0 at the accepted smiReq, and base + FC00h when it was 1. A change of wideMode during the handler has no effect on saveLo.
- R6: An smiReq while inSmm is 1 is ignored: no memory access starts, and entryValid and entryAddr stay unchanged.
- R7: An rsmReq while entryValid is high starts one read with memWe=0 and memAddr = base + FEF8h. An rsmReq while inSmm is 0 is ignored: no access, and inSmm stays 0.
- R8: The base output takes the memRdata value returned with the read acknowledge in the cycle after that acknowledge, and inSmm falls in the same cycle. The next entry uses the new base for every derived address.
- R9: All derived addresses are computed modulo 2^32. With base FFFF_8000h, entryAddr is 0000_0000h and saveHi is 0000_7FFFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| smiReq | input | 1 | Request to enter management mode |
| rsmReq | input | 1 | Request to resume and reload the base |
| wideMode | input | 1 | 1 selects the 400h-byte save area, 0 selects the 200h-byte one; sampled at entry |
| memReq | output | 1 | Memory access request, held until acknowledged |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | 32 | Access address (the base save slot) |
| memWdata | output | 32 | Write data (the current base) |
| memAck | input | 1 | Access acknowledge; read data is valid in the same cycle |
| memRdata | input | 32 | Read data |
| inSmm | output | 1 | Core is in management mode |
| entryValid | output | 1 | Entry address is valid |
| saveDone | output | 1 | One-cycle pulse when the base save write completes |
| entryAddr | output | 32 | Handler entry address |
| saveLo | output | 32 | Lowest byte address of the state-save area |
| saveHi | output | 32 | Highest byte address of the state-save area |
| baseOut | output | 32 | Current base register |

## Verification
The bench builds the unit with its default parameters: 32-bit addresses, reset base 0003_0000h, entry offset 8000h, save slot at FEF8h and save sizes of 200h and 400h. With 32-bit addresses, a relocated base of FFFF_8000h pushes the entry and upper-bound sums past the top of the address space, so the wrap case is reachable. The bench also varies the acknowledge latency from zero to three cycles, which exercises both a completion in the first cycle and a request held across several cycles.

// File: rtl/sysmgmt_base_pkg.sv
package sysmgmt_base_pkg;

  // Phases of one management-mode visit
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SAVE    = 2'd1,
    ST_HANDLER = 2'd2,
    ST_RESTORE = 2'd3
  } phase_t;

  // Strobes from the controller into the address datapath
  typedef struct packed {
    logic latchMode;
    logic loadBase;
  } dpStrobe_t;

endpackage

// File: rtl/sysmgmt_base_dp.sv
module sysmgmt_base_dp
  import sysmgmt_base_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter logic [31:0] RESET_BASE  = 32'h0003_0000,
  parameter int unsigned ENTRY_OFS   = 32'h8000,
  parameter int unsigned SLOT_OFS    = 32'hFEF8,
  parameter int unsigned TOP_OFS     = 32'hFFFF,
  parameter int unsigned NARROW_SIZE = 32'h200,
  parameter int unsigned WIDE_SIZE   = 32'h400
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              modeIn,
  input  logic [ADDR_W-1:0] rdData,
  output logic [ADDR_W-1:0] baseQ,
  output logic [ADDR_W-1:0] entryAddr,
  output logic [ADDR_W-1:0] slotAddr,
  output logic [ADDR_W-1:0] saveLo,
  output logic [ADDR_W-1:0] saveHi
);

  localparam logic [ADDR_W-1:0] ENTRY_K  = ADDR_W'(ENTRY_OFS);
  localparam logic [ADDR_W-1:0] SLOT_K   = ADDR_W'(SLOT_OFS);
  localparam logic [ADDR_W-1:0] TOP_K    = ADDR_W'(TOP_OFS);
  localparam logic [ADDR_W-1:0] NARROW_K = ADDR_W'(TOP_OFS + 1 - NARROW_SIZE);
  localparam logic [ADDR_W-1:0] WIDE_K   = ADDR_W'(TOP_OFS + 1 - WIDE_SIZE);

  logic wideQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ <= ADDR_W'(RESET_BASE);
      wideQ <= 1'b0;
    end else begin
      if (strobe.loadBase)  baseQ <= rdData;
      if (strobe.latchMode) wideQ <= modeIn;
    end
  end

  // All sums wrap modulo 2^ADDR_W
  always_comb begin
    entryAddr = baseQ + ENTRY_K;
    slotAddr  = baseQ + SLOT_K;
    saveHi    = baseQ + TOP_K;
    saveLo    = baseQ + (wideQ ? WIDE_K : NARROW_K);
  end

  // R8
  base_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadBase |=> baseQ == $past(rdData));

  // R5
  save_bound_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.latchMode && !strobe.loadBase |=> $stable(saveLo) && $stable(saveHi));

endmodule

// File: rtl/sysmgmt_base_ctrl.sv
module sysmgmt_base_ctrl
  import sysmgmt_base_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      smiReq,
  input  logic      rsmReq,
  input  logic      memAck,
  output dpStrobe_t strobe,
  output logic      memReq,
  output logic      memWe,
  output logic      inSmm,
  output logic      entryValid,
  output logic      saveDone
);

  phase_t phase, phaseNx;
  logic   doneQ;

  always_comb begin
    phaseNx = phase;
    unique case (phase)
      ST_IDLE:    if (smiReq) phaseNx = ST_SAVE;
      ST_SAVE:    if (memAck) phaseNx = ST_HANDLER;
      ST_HANDLER: if (rsmReq) phaseNx = ST_RESTORE;
      ST_RESTORE: if (memAck) phaseNx = ST_IDLE;
      default:                phaseNx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= ST_IDLE;
      doneQ <= 1'b0;
    end else begin
      phase <= phaseNx;
      doneQ <= (phase == ST_SAVE) && memAck;
    end
  end

  always_comb begin
    strobe.latchMode = (phase == ST_IDLE) && smiReq;
    strobe.loadBase  = (phase == ST_RESTORE) && memAck;
    memReq           = (phase == ST_SAVE) || (phase == ST_RESTORE);
    memWe            = (phase == ST_SAVE);
    inSmm            = (phase != ST_IDLE);
    entryValid       = (phase == ST_HANDLER);
    saveDone         = doneQ;
  end

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memWe));

  // R4
  done_with_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    saveDone |-> entryValid);

  // R4
  entry_after_save_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(entryValid) |-> saveDone);

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    saveDone |=> !saveDone);

  // R6
  handler_stays_chk: assert property (@(posedge clk) disable iff (!rstN)
    entryValid && !rsmReq |=> entryValid && !memReq);

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inSmm && !smiReq |=> !memReq && !inSmm);

  // R8
  exit_after_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memWe && memAck |=> !inSmm);

endmodule

// File: rtl/sysmgmt_base_unit.sv
module sysmgmt_base_unit
  import sysmgmt_base_pkg::*;
#(
  parameter logic [31:0] RESET_BASE = 32'h0003_0000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        smiReq,
  input  logic        rsmReq,
  input  logic        wideMode,
  output logic        memReq,
  output logic        memWe,
  output logic [31:0] memAddr,
  output logic [31:0] memWdata,
  input  logic        memAck,
  input  logic [31:0] memRdata,
  output logic        inSmm,
  output logic        entryValid,
  output logic        saveDone,
  output logic [31:0] entryAddr,
  output logic [31:0] saveLo,
  output logic [31:0] saveHi,
  output logic [31:0] baseOut
);

  dpStrobe_t strobe;

  sysmgmt_base_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .smiReq     (smiReq),
    .rsmReq     (rsmReq),
    .memAck     (memAck),
    .strobe     (strobe),
    .memReq     (memReq),
    .memWe      (memWe),
    .inSmm      (inSmm),
    .entryValid (entryValid),
    .saveDone   (saveDone)
  );

  sysmgmt_base_dp #(
    .ADDR_W     (32),
    .RESET_BASE (RESET_BASE)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .modeIn    (wideMode),
    .rdData    (memRdata),
    .baseQ     (baseOut),
    .entryAddr (entryAddr),
    .slotAddr  (memAddr),
    .saveLo    (saveLo),
    .saveHi    (saveHi)
  );

  assign memWdata = baseOut;

  // R3
  addr_data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> $stable(memAddr) && $stable(memWdata));

endmodule

// File: tb/sysmgmt_base_unit_test.sv
`timescale 1ns/1ps
module sysmgmt_base_unit_test;

  logic        clk = 1'b0;
  logic        rstN, smiReq, rsmReq, wideMode, memAck;
  logic [31:0] memRdata;
  logic        memReq, memWe, inSmm, entryValid, saveDone;
  logic [31:0] memAddr, memWdata, entryAddr, saveLo, saveHi, baseOut;

  always #10 clk = ~clk;

  sysmgmt_base_unit uut (
    .clk(clk), .rstN(rstN), .smiReq(smiReq), .rsmReq(rsmReq), .wideMode(wideMode),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memAck(memAck), .memRdata(memRdata), .inSmm(inSmm), .entryValid(entryValid),
    .saveDone(saveDone), .entryAddr(entryAddr), .saveLo(saveLo), .saveHi(saveHi),
    .baseOut(baseOut)
  );

  typedef struct {
    logic        we;
    logic [31:0] addr;
    logic [31:0] data;
  } memTxn_t;

  memTxn_t     expQ[$];
  memTxn_t     expItem;
  int          checks = 0;
  int          failures = 0;
  int          ackDelay = 0;
  int          waitCnt = 0;
  int          txnCount = 0;
  bit          finished = 0;
  logic [31:0] slotMem = 32'h0;

  task automatic chkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Memory responder and scoreboard monitor
  always @(negedge clk) begin
    if (!rstN) begin
      memAck  = 1'b0;
      waitCnt = 0;
    end else if (memAck) begin
      memAck = 1'b0;
    end else if (memReq) begin
      if (waitCnt >= ackDelay) begin
        waitCnt = 0;
        memAck  = 1'b1;
        if (memWe) slotMem = memWdata;
        memRdata = slotMem;
        txnCount++;
        if (expQ.size() == 0) begin
          checks++;
          failures++;
          $display("FAIL R6/R7 unexpected access actual=%h expected=none", memAddr);
        end else begin
          expItem = expQ.pop_front();
          chkEq("R3/R7 access direction", {31'b0, memWe}, {31'b0, expItem.we});
          chkEq("R3/R7 slot address", memAddr, expItem.addr);
          if (expItem.we) chkEq("R3 saved base data", memWdata, expItem.data);
        end
      end else begin
        waitCnt++;
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic enterSmm(input bit wide, input int dly, input logic [31:0] curBase);
    int n;
    ackDelay = dly;
    wideMode = wide;
    expQ.push_back('{1'b1, curBase + 32'hFEF8, curBase});
    smiReq = 1'b1;
    @(negedge clk);
    smiReq = 1'b0;
    chkEq("R4 inSmm after accept", {31'b0, inSmm}, 32'd1);
    n = 0;
    while (!entryValid && n < 50) begin
      @(negedge clk);
      n++;
    end
    chkEq("R4 saveDone with entryValid", {31'b0, saveDone}, 32'd1);
    chkEq("R4 write done before entry", expQ.size(), 32'd0);
    chkEq("R2 entry address", entryAddr, curBase + 32'h8000);
    chkEq("R5 save upper bound", saveHi, curBase + 32'hFFFF);
    chkEq("R5 save lower bound", saveLo, curBase + (wide ? 32'hFC00 : 32'hFE00));
    @(negedge clk);
    chkEq("R4 saveDone one cycle", {31'b0, saveDone}, 32'd0);
  endtask

  task automatic exitSmm(input logic [31:0] curBase, input logic [31:0] newBase);
    int n;
    ackDelay = 1;
    expQ.push_back('{1'b0, curBase + 32'hFEF8, 32'h0});
    rsmReq = 1'b1;
    @(negedge clk);
    rsmReq = 1'b0;
    n = 0;
    while (inSmm && n < 50) begin
      if (!memAck) chkEq("R8 base unchanged before read", baseOut, curBase);
      @(negedge clk);
      n++;
    end
    chkEq("R8 base reloaded", baseOut, newBase);
    chkEq("R8 entryValid low after resume", {31'b0, entryValid}, 32'd0);
    chkEq("R7 read completed", expQ.size(), 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int txn0;
    rstN = 1'b0; smiReq = 1'b0; rsmReq = 1'b0; wideMode = 1'b0;
    memAck = 1'b0; memRdata = 32'h0;
    tick(3);
    rstN = 1'b1;
    tick(1);

    // R1 reset state
    chkEq("R1 reset base", baseOut, 32'h0003_0000);
    chkEq("R1 inSmm", {31'b0, inSmm}, 32'd0);
    chkEq("R1 entryValid", {31'b0, entryValid}, 32'd0);
    chkEq("R1 saveDone", {31'b0, saveDone}, 32'd0);
    chkEq("R1 memReq", {31'b0, memReq}, 32'd0);

    // R7 resume outside management mode is ignored
    rsmReq = 1'b1; tick(1); rsmReq = 1'b0; tick(3);
    chkEq("R7 ignored resume inSmm", {31'b0, inSmm}, 32'd0);
    chkEq("R7 ignored resume no access", txnCount, 32'd0);

    // First entry, narrow save area
    enterSmm(1'b0, 0, 32'h0003_0000);
    chkEq("R2 first entry 38000h", entryAddr, 32'h0003_8000);
    chkEq("R3 slot holds base", slotMem, 32'h0003_0000);

    // R5 mode change during handler has no effect
    wideMode = 1'b1; tick(2);
    chkEq("R5 lower bound unaffected", saveLo, 32'h0003_FE00);

    // R6 entry request while inside is ignored
    txn0 = txnCount;
    smiReq = 1'b1; tick(2); smiReq = 1'b0; tick(2);
    chkEq("R6 still in handler", {31'b0, entryValid}, 32'd1);
    chkEq("R6 no new access", txnCount, txn0);
    chkEq("R6 entry unchanged", entryAddr, 32'h0003_8000);

    // Handler relocates by editing the slot
    slotMem = 32'hDFEF_8000;
    exitSmm(32'h0003_0000, 32'hDFEF_8000);

    // R8 next entry uses the new base; wide area, slow ack
    enterSmm(1'b1, 3, 32'hDFEF_8000);
    chkEq("R8 relocated entry", entryAddr, 32'hDFF0_0000);
    chkEq("R5 wide lower bound", saveLo, 32'hDFF0_7C00);
    exitSmm(32'hDFEF_8000, 32'hDFEF_8000);

    // R9 wrap-around
    enterSmm(1'b0, 1, 32'hDFEF_8000);
    slotMem = 32'hFFFF_8000;
    exitSmm(32'hDFEF_8000, 32'hFFFF_8000);
    enterSmm(1'b1, 0, 32'hFFFF_8000);
    chkEq("R9 entry wraps", entryAddr, 32'h0000_0000);
    chkEq("R9 upper bound wraps", saveHi, 32'h0000_7FFF);
    exitSmm(32'hFFFF_8000, 32'hFFFF_8000);

    tick(2);
    chkEq("R3 no pending accesses", expQ.size(), 32'd0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule